// File: doc/BRIEF.md
# Windowed Trigger Watchdog

This block supervises a periodic trigger pulse sent by a host. Once switched on, it first waits in a long start-up window for the host to come alive. After that it cycles through a closed window, where a trigger is premature, and an open window, where a trigger is expected. Each missed or premature trigger is a bad event. Each well-timed trigger is a good event. A small fail counter rises and falls with these events. When it passes a programmable limit, the block raises a fail interrupt. A second counter counts fail interrupts. When it passes its own limit, the block raises a reset interrupt and can issue a reset request.

Software sets the block up through a simple write port. Address 0 holds the control bits. Addresses 1 to 3 hold the window lengths in clock cycles. Address 4 holds the two thresholds. Address 5 clears status flags. Error flags, the fail count and the three escalation outputs come out as registered ports. Window lengths are counted in clock cycles, and a length of 0 acts as a length of 1.

Top module: `trig_watchdog`

## Requirements
- R1: While the enable bit (address 0, bit 0) is 0, no window runs and the fail count and error flags do not change, whatever the trigger does. Writing 1 to a status bit still clears it.
- R2: Enabling starts the long window, whose length is set at address 1. A trigger inside it moves to the closed window, with no error and no count change. If the long window runs out, status bit 0 is set and the long window restarts, with no count change.
- R3: A trigger during the closed window (length at address 2) sets status bit 2, counts as a bad event and restarts the closed window. If no trigger arrives, the closed window hands over to the open window.
- R4: A trigger during the open window (length at address 3) is a good event and starts a new closed window. If the open window ends with no trigger, status bit 1 is set, a bad event is counted and a closed window starts.
- R5: The 3-bit fail count rises by one on each bad event and stays at 7 once it reaches 7. It falls by one on each good event while it is nonzero.
- R6: Each bad event that leaves the fail count above the fail threshold (address 4, bits 2:0) fires a fail event and sets status bit 6.
- R7: A reset counter counts fail events. When it exceeds the reset threshold (address 4, bits 6:4), status bit 7 is set and both counters return to zero.
- R8: When the reset-enable bit (address 0, bit 1) is 1, each reset event produces a one-cycle pulse on `rst_req_o`. When it is 0, there is no pulse.
- R9: When the return-to-long bit (address 0, bit 2) is 1, a reset event sends the block back to the long window. When it is 0, the closed/open cycle goes on.
- R10: Writing to address 5 clears every status bit written as 1. A new event in the same cycle wins over the clear. Status bits 3 to 5 always read 0. `fail_irq_o` and `rst_irq_o` mirror status bits 6 and 7.
- R11: The trigger passes through two synchronizing flops and acts on its rising edge only, so a trigger held high counts as a single event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| trig_i | input | 1 | Asynchronous trigger from the host |
| err_flags_o | output | 8 | Sticky status flags |
| fail_cnt_o | output | 3 | Current fail count |
| fail_irq_o | output | 1 | Fail interrupt flag |
| rst_irq_o | output | 1 | Reset interrupt flag |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The main sweep covers every fail threshold against bursts of 0 to 9 premature triggers. The final count separates correct saturation from wrap-around, and the fail flag separates a strict greater-than test from greater-or-equal. A second sweep runs each reset threshold with one bad event fewer than needed, then with exactly enough, which pins down where escalation starts. Well-timed triggers placed in the open window check the decrement path. Silent stretches check both timeouts. A trigger sent just after a reset event tells the return-to-long path apart from the continue path. A trigger held high for many cycles shows that only the edge is counted.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int THR_W  = 3;
  localparam int FLAG_W = 8;

  localparam int FL_LONG_TO = 0;
  localparam int FL_TIMEOUT = 1;
  localparam int FL_EARLY   = 2;
  localparam int FL_FAIL    = 6;
  localparam int FL_RESET   = 7;

  localparam int A_CTRL   = 0;
  localparam int A_LONG   = 1;
  localparam int A_CLOSED = 2;
  localparam int A_OPEN   = 3;
  localparam int A_THRESH = 4;
  localparam int A_STATUS = 5;

  typedef enum logic [1:0] {
    PH_OFF    = 2'd0,
    PH_LONG   = 2'd1,
    PH_CLOSED = 2'd2,
    PH_OPEN   = 2'd3
  } phase_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], trig_i};
  end

  // chain_q[STAGES] is the delayed copy used for edge detection
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/window_timer.sv
module window_timer
  import wdg_pkg::*;
#(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic [DUR_W-1:0] long_dur_i,
  input  logic [DUR_W-1:0] closed_dur_i,
  input  logic [DUR_W-1:0] open_dur_i,
  input  logic             trig_rise_i,
  input  logic             go_long_i,
  output logic             long_to_o,
  output logic             timeout_o,
  output logic             early_o,
  output logic             good_o
);
  phase_e           phase_q, phase_d;
  logic [DUR_W-1:0] tick_q, tick_d;
  logic [DUR_W:0]   tick_inc;
  logic             end_long, end_closed, end_open;

  assign tick_inc   = {1'b0, tick_q} + 1'b1;
  assign end_long   = tick_inc >= {1'b0, long_dur_i};
  assign end_closed = tick_inc >= {1'b0, closed_dur_i};
  assign end_open   = tick_inc >= {1'b0, open_dur_i};

  always_comb begin
    phase_d   = phase_q;
    tick_d    = tick_inc[DUR_W-1:0];
    long_to_o = 1'b0;
    timeout_o = 1'b0;
    early_o   = 1'b0;
    good_o    = 1'b0;
    if (!enable_i) begin
      phase_d = PH_OFF;
      tick_d  = '0;
    end else begin
      unique case (phase_q)
        PH_OFF: begin
          phase_d = PH_LONG;
          tick_d  = '0;
        end
        PH_LONG: begin
          if (trig_rise_i) begin
            phase_d = PH_CLOSED;
            tick_d  = '0;
          end else if (end_long) begin
            long_to_o = 1'b1;
            tick_d    = '0;
          end
        end
        PH_CLOSED: begin
          if (trig_rise_i) begin
            early_o = 1'b1;
            tick_d  = '0;
          end else if (end_closed) begin
            phase_d = PH_OPEN;
            tick_d  = '0;
          end
        end
        PH_OPEN: begin
          if (trig_rise_i) begin
            good_o  = 1'b1;
            phase_d = PH_CLOSED;
            tick_d  = '0;
          end else if (end_open) begin
            timeout_o = 1'b1;
            phase_d   = PH_CLOSED;
            tick_d    = '0;
          end
        end
        default: begin
          phase_d = PH_OFF;
          tick_d  = '0;
        end
      endcase
      if (go_long_i) begin
        phase_d = PH_LONG;
        tick_d  = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_OFF;
      tick_q  <= '0;
    end else begin
      phase_q <= phase_d;
      tick_q  <= tick_d;
    end
  end

  a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> phase_q == PH_OFF);
  a_r2_enable_enters_long: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_OFF && enable_i) |=> phase_q == PH_LONG);
  a_r3_early_stays_closed: assert property (@(posedge clk) disable iff (rst)
    (early_o && !go_long_i) |=> (phase_q == PH_CLOSED && tick_q == '0));
endmodule

// File: rtl/fail_escalator.sv
module fail_escalator
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bad_i,
  input  logic             good_i,
  input  logic [THR_W-1:0] fail_thr_i,
  input  logic [THR_W-1:0] rst_thr_i,
  input  logic             rst_en_i,
  input  logic             ret_long_i,
  output logic [THR_W-1:0] fail_cnt_o,
  output logic             fail_evt_o,
  output logic             rst_evt_o,
  output logic             go_long_o,
  output logic             rst_req_o
);
  localparam int RCNT_W = THR_W + 1;
  localparam logic [THR_W-1:0] FAIL_MAX = {THR_W{1'b1}};

  logic [THR_W-1:0]  fail_q, fail_next, fail_d;
  logic [RCNT_W-1:0] rcnt_q, rcnt_next, rcnt_d;
  logic              req_q;

  always_comb begin
    fail_next = fail_q;
    if (bad_i) begin
      if (fail_q != FAIL_MAX) fail_next = fail_q + 1'b1;
    end else if (good_i && fail_q != '0) begin
      fail_next = fail_q - 1'b1;
    end
    fail_evt_o = bad_i && (fail_next > fail_thr_i);
    rcnt_next  = fail_evt_o ? rcnt_q + 1'b1 : rcnt_q;
    rst_evt_o  = fail_evt_o && (rcnt_next > {1'b0, rst_thr_i});
    fail_d     = rst_evt_o ? '0 : fail_next;
    rcnt_d     = rst_evt_o ? '0 : rcnt_next;
    go_long_o  = rst_evt_o && ret_long_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_q <= '0;
      rcnt_q <= '0;
      req_q  <= 1'b0;
    end else begin
      fail_q <= fail_d;
      rcnt_q <= rcnt_d;
      req_q  <= rst_evt_o && rst_en_i;
    end
  end

  assign fail_cnt_o = fail_q;
  assign rst_req_o  = req_q;

  a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
    (bad_i && fail_q == FAIL_MAX && !rst_evt_o) |=> fail_q == FAIL_MAX);
  a_r5_decrement: assert property (@(posedge clk) disable iff (rst)
    (good_i && !bad_i && fail_q != '0) |=> fail_q == $past(fail_q) - 1'b1);
  a_r7_clear_on_reset: assert property (@(posedge clk) disable iff (rst)
    rst_evt_o |=> (fail_q == '0 && rcnt_q == '0));
endmodule

// File: rtl/trig_watchdog.sv
module trig_watchdog
  import wdg_pkg::*;
#(
  parameter int DUR_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [DUR_W-1:0] LONG_INIT   = 16'd1000,
  parameter logic [DUR_W-1:0] CLOSED_INIT = 16'd100,
  parameter logic [DUR_W-1:0] OPEN_INIT   = 16'd100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DUR_W-1:0]  cfg_wdata,
  input  logic              trig_i,
  output logic [FLAG_W-1:0] err_flags_o,
  output logic [THR_W-1:0]  fail_cnt_o,
  output logic              fail_irq_o,
  output logic              rst_irq_o,
  output logic              rst_req_o
);
  logic             en_q, rst_en_q, ret_long_q;
  logic [DUR_W-1:0] long_q, closed_q, open_q;
  logic [THR_W-1:0] fail_thr_q, rst_thr_q;
  logic [FLAG_W-1:0] flags_q, flag_set, flag_clr;

  logic trig_rise, long_to, timeout, early, good;
  logic fail_evt, rst_evt, go_long;

  logic wr_ctrl, wr_long, wr_closed, wr_open, wr_thresh, wr_status;
  assign wr_ctrl   = cfg_we && cfg_addr == ADDR_W'(A_CTRL);
  assign wr_long   = cfg_we && cfg_addr == ADDR_W'(A_LONG);
  assign wr_closed = cfg_we && cfg_addr == ADDR_W'(A_CLOSED);
  assign wr_open   = cfg_we && cfg_addr == ADDR_W'(A_OPEN);
  assign wr_thresh = cfg_we && cfg_addr == ADDR_W'(A_THRESH);
  assign wr_status = cfg_we && cfg_addr == ADDR_W'(A_STATUS);

  logic unused_wdata;
  assign unused_wdata = ^{cfg_wdata[DUR_W-1:FLAG_W], cfg_wdata[3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      rst_en_q   <= 1'b0;
      ret_long_q <= 1'b0;
      long_q     <= LONG_INIT;
      closed_q   <= CLOSED_INIT;
      open_q     <= OPEN_INIT;
      fail_thr_q <= '0;
      rst_thr_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q       <= cfg_wdata[0];
        rst_en_q   <= cfg_wdata[1];
        ret_long_q <= cfg_wdata[2];
      end
      if (wr_long)   long_q   <= cfg_wdata;
      if (wr_closed) closed_q <= cfg_wdata;
      if (wr_open)   open_q   <= cfg_wdata;
      if (wr_thresh) begin
        fail_thr_q <= cfg_wdata[THR_W-1:0];
        rst_thr_q  <= cfg_wdata[4+THR_W-1:4];
      end
    end
  end

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .trig_i (trig_i),
    .rise_o (trig_rise)
  );

  window_timer #(.DUR_W(DUR_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .enable_i     (en_q),
    .long_dur_i   (long_q),
    .closed_dur_i (closed_q),
    .open_dur_i   (open_q),
    .trig_rise_i  (trig_rise),
    .go_long_i    (go_long),
    .long_to_o    (long_to),
    .timeout_o    (timeout),
    .early_o      (early),
    .good_o       (good)
  );

  fail_escalator u_esc (
    .clk        (clk),
    .rst        (rst),
    .bad_i      (early | timeout),
    .good_i     (good),
    .fail_thr_i (fail_thr_q),
    .rst_thr_i  (rst_thr_q),
    .rst_en_i   (rst_en_q),
    .ret_long_i (ret_long_q),
    .fail_cnt_o (fail_cnt_o),
    .fail_evt_o (fail_evt),
    .rst_evt_o  (rst_evt),
    .go_long_o  (go_long),
    .rst_req_o  (rst_req_o)
  );

  always_comb begin
    flag_set             = '0;
    flag_set[FL_LONG_TO] = long_to;
    flag_set[FL_TIMEOUT] = timeout;
    flag_set[FL_EARLY]   = early;
    flag_set[FL_FAIL]    = fail_evt;
    flag_set[FL_RESET]   = rst_evt;
    flag_clr = wr_status ? cfg_wdata[FLAG_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  assign err_flags_o = flags_q;
  assign fail_irq_o  = flags_q[FL_FAIL];
  assign rst_irq_o   = flags_q[FL_RESET];

  a_r1_count_frozen_off: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> $stable(fail_cnt_o));
  a_r3_early_flagged: assert property (@(posedge clk) disable iff (rst)
    early |=> err_flags_o[FL_EARLY]);
  a_r8_req_has_irq: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> rst_irq_o);
  a_r10_answer_bits_low: assert property (@(posedge clk) disable iff (rst)
    wr_status |=> err_flags_o[5:3] == 3'b000);
endmodule

// File: tb/tb_trig_watchdog.sv
module tb_trig_watchdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        trig_i = 1'b0;
  logic [7:0]  err_flags_o;
  logic [2:0]  fail_cnt_o;
  logic        fail_irq_o, rst_irq_o, rst_req_o;

  int checks = 0;
  int failures = 0;
  int req_pulses = 0;

  always #5 clk = ~clk;

  trig_watchdog dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig_i(trig_i), .err_flags_o(err_flags_o),
    .fail_cnt_o(fail_cnt_o), .fail_irq_o(fail_irq_o), .rst_irq_o(rst_irq_o),
    .rst_req_o(rst_req_o)
  );

  always @(negedge clk) if (!rst && rst_req_o) req_pulses++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_i = 1'b1;
    @(negedge clk);
    @(negedge clk); trig_i = 1'b0;
  endtask

  // long=40, closed=20, open=20; leaves the long window with a trigger
  task automatic restart(int ft, int rt, int ren, int rlong, bit leave);
    @(negedge clk); rst = 1'b1;
    wait_n(2); rst = 1'b0;
    wr(1, 40); wr(2, 20); wr(3, 20);
    wr(4, (rt << 4) | ft);
    wr(0, (rlong << 2) | (ren << 1) | 1);
    req_pulses = 0;
    if (leave) begin
      wait_n(5);
      pulse_trig();
      wait_n(5);
    end
  endtask

  task automatic early_burst(int n);
    for (int i = 0; i < n; i++) begin
      pulse_trig();
      wait_n(7);
    end
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired before completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(2);
    chk("reset flags", int'(err_flags_o), 0);
    chk("reset fail count", int'(fail_cnt_o), 0);
    chk("reset request", int'(rst_req_o), 0);

    // R2: long window expiry, bit 0
    restart(7, 7, 0, 0, 1'b0);
    wait_n(30);
    chk("R2 no early long timeout", int'(err_flags_o[0]), 0);
    wait_n(15);
    chk("R2 long timeout flag", int'(err_flags_o[0]), 1);
    chk("R2 no count on long timeout", int'(fail_cnt_o), 0);
    chk("R2 no timeout flag in long", int'(err_flags_o[1]), 0);
    // R10: write one to clear bit 0 only
    wr(5, 1);
    chk("R10 w1c clears bit0", int'(err_flags_o), 0);

    // R2 quiet exit, R4 timeout in open window
    restart(7, 7, 0, 0, 1'b1);
    chk("R2 trigger in long is quiet", int'(err_flags_o), 0);
    wait_n(38);
    chk("R4 timeout count", int'(fail_cnt_o), 1);
    chk("R4 timeout flag", int'(err_flags_o[1]), 1);
    chk("R4 timeout not early", int'(err_flags_o[2]), 0);
    wait_n(40);
    chk("R4 second timeout", int'(fail_cnt_o), 2);

    // R1: disabled block ignores triggers
    wr(0, 0);
    begin
      automatic logic [7:0] snap = err_flags_o;
      for (int i = 0; i < 6; i++) begin pulse_trig(); wait_n(30); end
      chk("R1 flags frozen", int'(err_flags_o), int'(snap));
      chk("R1 count frozen", int'(fail_cnt_o), 2);
    end

    // R5 good-event decrement, R4 good in open window
    restart(7, 7, 0, 0, 1'b1);
    early_burst(3);
    chk("R5 three bad events", int'(fail_cnt_o), 3);
    wait_n(21); pulse_trig(); wait_n(3);
    chk("R5 decrement on good", int'(fail_cnt_o), 2);
    wait_n(25); pulse_trig(); wait_n(3);
    chk("R5 second decrement", int'(fail_cnt_o), 1);
    chk("R4 good event no timeout", int'(err_flags_o[1]), 0);

    // R11: held trigger counts once
    restart(7, 7, 0, 0, 1'b1);
    @(negedge clk); trig_i = 1'b1;
    wait_n(15); trig_i = 1'b0;
    wait_n(3);
    chk("R11 held trigger single event", int'(fail_cnt_o), 1);
    chk("R3 early flag on held trigger", int'(err_flags_o[2]), 1);

    // R3/R5/R6 sweep: fail threshold x burst length
    for (int ft = 0; ft < 8; ft++) begin
      for (int n = 0; n < 10; n++) begin
        if (ft < 7 && n - ft > 7) continue;
        restart(ft, 7, 0, 0, 1'b1);
        early_burst(n);
        chk($sformatf("R5 count ft=%0d n=%0d", ft, n), int'(fail_cnt_o), (n > 7) ? 7 : n);
        chk($sformatf("R6 fail irq ft=%0d n=%0d", ft, n), int'(fail_irq_o),
            (((n > 7) ? 7 : n) > ft) ? 1 : 0);
        chk($sformatf("R3 early flag n=%0d", n), int'(err_flags_o[2]), (n > 0) ? 1 : 0);
        chk($sformatf("R7 no reset ft=%0d n=%0d", ft, n), int'(rst_irq_o), 0);
      end
    end

    // R7/R8 sweep over reset threshold with fail threshold 0
    for (int rt = 0; rt < 8; rt++) begin
      restart(0, rt, 1, 0, 1'b1);
      early_burst(rt);
      chk($sformatf("R7 below reset rt=%0d", rt), int'(rst_irq_o), 0);
      chk($sformatf("R7 count below rt=%0d", rt), int'(fail_cnt_o), rt);
      chk($sformatf("R8 no req rt=%0d", rt), req_pulses, 0);
      restart(0, rt, 1, 0, 1'b1);
      early_burst(rt + 1);
      chk($sformatf("R7 reset irq rt=%0d", rt), int'(rst_irq_o), 1);
      chk($sformatf("R7 counters cleared rt=%0d", rt), int'(fail_cnt_o), 0);
      chk($sformatf("R8 one req pulse rt=%0d", rt), req_pulses, 1);
    end

    // R8: reset enable off gives no request
    restart(0, 1, 0, 0, 1'b1);
    early_burst(2);
    chk("R8 irq without enable", int'(rst_irq_o), 1);
    chk("R8 no request without enable", req_pulses, 0);

    // R9: return to long window after a reset event
    restart(0, 0, 1, 1, 1'b1);
    early_burst(1);
    chk("R9 reset event", int'(rst_irq_o), 1);
    wr(5, 255);
    chk("R10 clear all flags", int'(err_flags_o), 0);
    pulse_trig(); wait_n(5);
    chk("R9 trigger in long after reset is quiet", int'(err_flags_o), 0);
    restart(0, 0, 1, 0, 1'b1);
    early_burst(1);
    wr(5, 255);
    pulse_trig(); wait_n(5);
    chk("R9 without return trigger is early", int'(err_flags_o[2]), 1);
    chk("R10 answer bits zero", int'(err_flags_o[5:3]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule